// File: doc/BRIEF.md
# Dual-Clock Registered-Input Dual-Port RAM

The block is a 4096-word by 9-bit static memory that two independent ports can use at once. Each port, left and right, has its own clock, an active-low clock enable, an active-low chip enable, a read/write level, an asynchronous active-low output enable, a 12-bit address and a 9-bit data input. All addresses, data and control levels are captured in input registers on the rising edge of the port's own clock. The operation decoded from those registers runs on the next edge of that clock: a write stores the word, and a read loads the port's output register. The ninth bit has no special meaning and is stored like the other bits.

There are no tri-state pads. Each port has a read-valid flag instead, which marks when its data output would be driven. The flag falls at once when the output enable goes high, and it stays low while the registered state is a deselect or a write. When one port writes a word and the other port reads the same address soon after, the read returns the older contents. This continues for a configurable number of reader clock cycles, which models the minimum clock-to-clock spacing. If both ports write one address on the same edge, the left port's data is kept.

Top module: `dpr_sync_top`

## Requirements
- R1: The array holds 2**AW words of DW bits (defaults 4096 and 9, address 12 bits). Both ports may access it in the same cycle. A read returns the last value stored at that address, all 9 bits including the top one.
- R2: A read is registered at rising edge n of the port's clock when clock enable is low, chip enable is low and read/write is high. rdata_x_o takes the word at edge n+1. rdata_x_o then keeps that value through later writes and deselects, until the next registered read loads it.
- R3: While clock enable is high at a rising edge, the port's input registers keep their contents and no operation starts. rdata_x_o does not change, and no write of the presented data happens.
- R4: A registered chip enable high deselects the port. rvalid_x_o is low from the end of that edge, whatever the read/write and output-enable levels are. A write presented with chip enable high stores nothing.
- R5: The output enable is asynchronous. When oe_x_ni is high, rvalid_x_o is low with no clock edge needed. When oe_x_ni returns low while a read is registered and its data loaded, rvalid_x_o returns high.
- R6: A write is registered when chip enable and read/write are both low at edge n. It is stored at edge n+1. rvalid_x_o is low while the write is the registered state. A read of the same address on the same port, registered at edge n+1, returns the new word.
- R7: Port A registers a write at edge n. Port B registers a read of the same address at its k-th edge after n, counting the shared edge as k=0. With window WIN (default 1), the read returns the old word for k from 0 to WIN and the new word for k greater than WIN.
- R8: If both ports register a write to the same address at the same edge, the left port's data is stored. Writes to different addresses on the same edge are both stored.
- R9: While rst_ni is low, both ports are deselected with no operation pending, both rvalid outputs are low and both rdata outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for both ports |
| clk_l_i | input | 1 | Left port clock |
| cke_l_ni | input | 1 | Left clock enable, low loads the input registers |
| ce_l_ni | input | 1 | Left chip enable, low selects |
| wr_l_ni | input | 1 | Left read/write, low writes, high reads |
| oe_l_ni | input | 1 | Left asynchronous output enable, low enables |
| addr_l_i | input | AW | Left address |
| wdata_l_i | input | DW | Left write data |
| rdata_l_o | output | DW | Left read data register |
| rvalid_l_o | output | 1 | Left output-driven flag |
| clk_r_i | input | 1 | Right port clock |
| cke_r_ni | input | 1 | Right clock enable, low loads the input registers |
| ce_r_ni | input | 1 | Right chip enable, low selects |
| wr_r_ni | input | 1 | Right read/write, low writes, high reads |
| oe_r_ni | input | 1 | Right asynchronous output enable, low enables |
| addr_r_i | input | AW | Right address |
| wdata_r_i | input | DW | Right write data |
| rdata_r_o | output | DW | Right read data register |
| rvalid_r_o | output | 1 | Right output-driven flag |

## Verification
The assertions assume that each port's control inputs are settled at its rising clock edge, and that the reset is entered through a falling edge of rst_ni. The forwarding and collision checks also assume that both clocks are edge-aligned, so that "the same edge" and "the k-th edge" are well defined. To stay within these limits, the stimulus changes inputs only at falling edges, drives both port clocks from one source, and starts reset from a high level. The only exception is the output enable: it is toggled between edges on purpose, to show that it is asynchronous.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_DSL = 2'd3
  } op_e;
endpackage

// File: rtl/dpr_port_in.sv
module dpr_port_in
  import dpr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          ce_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_q_o,
  output logic [DW-1:0] wdata_q_o,
  output logic          sel_q_o,
  output logic          rd_q_o,
  output op_e           op_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      sel_q_o   <= 1'b0;
      rd_q_o    <= 1'b1;
      op_q_o    <= OP_NOP;
    end else if (!cke_ni) begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
      sel_q_o   <= ~ce_ni;
      rd_q_o    <= wr_ni;
      op_q_o    <= ce_ni ? OP_DSL : (wr_ni ? OP_RD : OP_WR);
    end else begin
      // registers frozen; nothing new is launched
      op_q_o <= OP_NOP;
    end
  end
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int AW  = 12,
  parameter int DW  = 9,
  parameter bit INV = 1'b0
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                lvt_src_i,
  input  logic [1:0][AW-1:0]  raddr_i,
  output logic [1:0][DW-1:0]  rdata_o,
  output logic [1:0]          rlvt_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          lvt [DEPTH];

  // lvt bit: left bank copies, right bank inverts; equal bits mean left is newest
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
      lvt[waddr_i] <= lvt_src_i ^ INV;
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_rd
    assign rdata_o[j] = mem[raddr_i[j]];
    assign rlvt_o[j]  = lvt[raddr_i[j]];
  end
endmodule

// File: rtl/dpr_window.sv
module dpr_window #(
  parameter int AW  = 12,
  parameter int DW  = 9,
  parameter int WIN = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tgl_i,
  input  logic [AW-1:0] caddr_i,
  input  logic [DW-1:0] cold_i,
  input  logic [AW-1:0] raddr_i,
  output logic          hit_o,
  output logic [DW-1:0] old_o
);
  localparam int CW = $clog2(WIN + 1);

  logic          tgl_seen;
  logic [CW-1:0] age;
  logic [AW-1:0] haz_addr;
  logic [DW-1:0] haz_old;
  logic          fresh, fresh_hit, held_hit;

  assign fresh     = tgl_seen != tgl_i;
  assign fresh_hit = fresh && (caddr_i == raddr_i);
  assign held_hit  = (age != '0) && (haz_addr == raddr_i);
  assign hit_o     = fresh_hit || held_hit;
  assign old_o     = fresh_hit ? cold_i : haz_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_seen <= 1'b0;
      age      <= '0;
      haz_addr <= '0;
      haz_old  <= '0;
    end else begin
      tgl_seen <= tgl_i;
      if (fresh) begin
        age      <= CW'(WIN - 1);
        haz_addr <= caddr_i;
        haz_old  <= cold_i;
      end else if (age != '0) begin
        age <= age - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dpr_sync_top.sv
module dpr_sync_top
  import dpr_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 9,
  parameter int WIN = 1
) (
  input  logic          rst_ni,
  input  logic          clk_l_i,
  input  logic          cke_l_ni,
  input  logic          ce_l_ni,
  input  logic          wr_l_ni,
  input  logic          oe_l_ni,
  input  logic [AW-1:0] addr_l_i,
  input  logic [DW-1:0] wdata_l_i,
  output logic [DW-1:0] rdata_l_o,
  output logic          rvalid_l_o,
  input  logic          clk_r_i,
  input  logic          cke_r_ni,
  input  logic          ce_r_ni,
  input  logic          wr_r_ni,
  input  logic          oe_r_ni,
  input  logic [AW-1:0] addr_r_i,
  input  logic [DW-1:0] wdata_r_i,
  output logic [DW-1:0] rdata_r_o,
  output logic          rvalid_r_o
);
  logic [1:0]               clk_s, cke_s, ce_s, wr_s, oe_s;
  logic [1:0][AW-1:0]       addr_s, addr_q, caddr_w;
  logic [1:0][DW-1:0]       wdata_s, wdata_q, latest, cold_w, rdata_w, old_w;
  logic [1:0]               sel_q, rd_q, wr_go, tgl_w, rvld_w, hit_w;
  logic [1:0][1:0]          op_q;
  logic [1:0][1:0][DW-1:0]  bdat;
  logic [1:0][1:0]          blvt;

  assign clk_s   = {clk_r_i, clk_l_i};
  assign cke_s   = {cke_r_ni, cke_l_ni};
  assign ce_s    = {ce_r_ni, ce_l_ni};
  assign wr_s    = {wr_r_ni, wr_l_ni};
  assign oe_s    = {oe_r_ni, oe_l_ni};
  assign addr_s  = {addr_r_i, addr_l_i};
  assign wdata_s = {wdata_r_i, wdata_l_i};

  // left wins a same-address, same-edge write
  assign wr_go[0] = op_q[0] == OP_WR;
  assign wr_go[1] = (op_q[1] == OP_WR) &&
                    !((op_q[0] == OP_WR) && (addr_q[0] == addr_q[1]));

  for (genvar i = 0; i < 2; i++) begin : g_bank
    dpr_bank #(.AW(AW), .DW(DW), .INV(i == 1)) u_bank (
      .clk_i     (clk_s[i]),
      .we_i      (wr_go[i]),
      .waddr_i   (addr_q[i]),
      .wdata_i   (wdata_q[i]),
      .lvt_src_i (blvt[1-i][i]),
      .raddr_i   (addr_q),
      .rdata_o   (bdat[i]),
      .rlvt_o    (blvt[i])
    );
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    op_e           op_e_w;
    logic [DW-1:0] rdata_r, cold_r;
    logic [AW-1:0] caddr_r;
    logic          rvld_r, tgl_r;

    dpr_port_in #(.AW(AW), .DW(DW)) u_in (
      .clk_i     (clk_s[p]),
      .rst_ni    (rst_ni),
      .cke_ni    (cke_s[p]),
      .ce_ni     (ce_s[p]),
      .wr_ni     (wr_s[p]),
      .addr_i    (addr_s[p]),
      .wdata_i   (wdata_s[p]),
      .addr_q_o  (addr_q[p]),
      .wdata_q_o (wdata_q[p]),
      .sel_q_o   (sel_q[p]),
      .rd_q_o    (rd_q[p]),
      .op_q_o    (op_e_w)
    );
    assign op_q[p] = op_e_w;

    assign latest[p] = (blvt[0][p] == blvt[1][p]) ? bdat[0][p] : bdat[1][p];

    dpr_window #(.AW(AW), .DW(DW), .WIN(WIN)) u_win (
      .clk_i   (clk_s[p]),
      .rst_ni  (rst_ni),
      .tgl_i   (tgl_w[1-p]),
      .caddr_i (caddr_w[1-p]),
      .cold_i  (cold_w[1-p]),
      .raddr_i (addr_q[p]),
      .hit_o   (hit_w[p]),
      .old_o   (old_w[p])
    );

    always_ff @(posedge clk_s[p] or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_r <= '0;
        rvld_r  <= 1'b0;
        tgl_r   <= 1'b0;
        caddr_r <= '0;
        cold_r  <= '0;
      end else begin
        case (op_e_w)
          OP_RD: begin
            rdata_r <= hit_w[p] ? old_w[p] : latest[p];
            rvld_r  <= 1'b1;
          end
          OP_WR, OP_DSL: rvld_r <= 1'b0;
          default: ;
        endcase
        if (wr_go[p]) begin
          tgl_r   <= ~tgl_r;
          caddr_r <= addr_q[p];
          cold_r  <= latest[p];
        end
      end
    end

    assign rdata_w[p] = rdata_r;
    assign rvld_w[p]  = rvld_r;
    assign tgl_w[p]   = tgl_r;
    assign caddr_w[p] = caddr_r;
    assign cold_w[p]  = cold_r;
  end

  assign rdata_l_o  = rdata_w[0];
  assign rdata_r_o  = rdata_w[1];
  assign rvalid_l_o = rvld_w[0] & sel_q[0] & rd_q[0] & ~oe_s[0];
  assign rvalid_r_o = rvld_w[1] & sel_q[1] & rd_q[1] & ~oe_s[1];
endmodule

// File: rtl/dpr_sync_chk.sv
module dpr_sync_chk #(
  parameter int DW = 9
) (
  input logic          rst_ni,
  input logic          clk_l_i,
  input logic          cke_l_ni,
  input logic          ce_l_ni,
  input logic          wr_l_ni,
  input logic          oe_l_ni,
  input logic [DW-1:0] rdata_l_o,
  input logic          rvalid_l_o,
  input logic          clk_r_i,
  input logic          cke_r_ni,
  input logic          ce_r_ni,
  input logic          wr_r_ni,
  input logic          oe_r_ni,
  input logic [DW-1:0] rdata_r_o,
  input logic          rvalid_r_o
);
  assert_hold_l_R3: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    $past(cke_l_ni) |=> $stable(rdata_l_o));
  assert_hold_r_R3: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    $past(cke_r_ni) |=> $stable(rdata_r_o));

  assert_desel_l_R4: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!cke_l_ni && ce_l_ni) |=> !rvalid_l_o);
  assert_desel_r_R4: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (!cke_r_ni && ce_r_ni) |=> !rvalid_r_o);

  assert_oe_l_R5: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    oe_l_ni |-> !rvalid_l_o);
  assert_oe_r_R5: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    oe_r_ni |-> !rvalid_r_o);

  assert_wr_off_l_R6: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!cke_l_ni && !ce_l_ni && !wr_l_ni) |=> !rvalid_l_o);
  assert_wr_off_r_R6: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (!cke_r_ni && !ce_r_ni && !wr_r_ni) |=> !rvalid_r_o);
endmodule

bind dpr_sync_top dpr_sync_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_dpr_sync_top.sv
module tb_dpr_sync_top;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic cke_l_ni, ce_l_ni, wr_l_ni, oe_l_ni;
  logic cke_r_ni, ce_r_ni, wr_r_ni, oe_r_ni;
  logic [AW-1:0] addr_l_i, addr_r_i;
  logic [DW-1:0] wdata_l_i, wdata_r_i, rdata_l_o, rdata_r_o;
  logic rvalid_l_o, rvalid_r_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dpr_sync_top #(.AW(AW), .DW(DW), .WIN(1)) dut (
    .rst_ni, .clk_l_i(clk), .cke_l_ni, .ce_l_ni, .wr_l_ni, .oe_l_ni,
    .addr_l_i, .wdata_l_i, .rdata_l_o, .rvalid_l_o,
    .clk_r_i(clk), .cke_r_ni, .ce_r_ni, .wr_r_ni, .oe_r_ni,
    .addr_r_i, .wdata_r_i, .rdata_r_o, .rvalid_r_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drv_l(input logic ce, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cke_l_ni = 1'b0; ce_l_ni = ce; wr_l_ni = wr; addr_l_i = a; wdata_l_i = d;
  endtask

  task automatic drv_r(input logic ce, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cke_r_ni = 1'b0; ce_r_ni = ce; wr_r_ni = wr; addr_r_i = a; wdata_r_i = d;
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drv_l(1'b0, 1'b0, a, d); tick(); drv_l(1'b1, 1'b1, '0, '0); tick();
  endtask

  task automatic wr_r(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drv_r(1'b0, 1'b0, a, d); tick(); drv_r(1'b1, 1'b1, '0, '0); tick();
  endtask

  task automatic rd_l(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    drv_l(1'b0, 1'b1, a, '0); tick(); tick();
    chk(tag, {rvalid_l_o, rdata_l_o}, {1'b1, e});
  endtask

  task automatic rd_r(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    drv_r(1'b0, 1'b1, a, '0); tick(); tick();
    chk(tag, {rvalid_r_o, rdata_r_o}, {1'b1, e});
  endtask

  task automatic t_reset();
    chk("R9 reset valid", {rvalid_l_o, rvalid_r_o}, 0);
    chk("R9 reset data", {rdata_l_o, rdata_r_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk("R9 idle after reset", {rvalid_l_o, rvalid_r_o}, 0);
  endtask

  task automatic t_basic();
    wr_l(12'd0, 9'h1FF);
    wr_l(12'd4095, 9'h0A5);
    wr_r(12'd123, 9'h15A);
    rd_l(12'd123, 9'h15A, "R1 left reads right write");
    rd_r(12'd0, 9'h1FF, "R1 ninth bit kept");
    rd_r(12'd4095, 9'h0A5, "R1 top address");
    rd_l(12'd4095, 9'h0A5, "R1 left top address");
  endtask

  task automatic t_latency();
    rd_l(12'd123, 9'h15A, "R2 setup");
    drv_l(1'b0, 1'b1, 12'd0, '0);
    tick();
    chk("R2 not yet updated", rdata_l_o, 9'h15A);
    tick();
    chk("R2 updated one edge later", rdata_l_o, 9'h1FF);
    wr_l(12'd7, 9'h003);
    chk("R2 held through write", rdata_l_o, 9'h1FF);
  endtask

  task automatic t_same_port();
    rd_l(12'd0, 9'h1FF, "R6 setup");
    drv_l(1'b0, 1'b0, 12'd10, 9'h111);
    tick();
    chk("R6 valid low during write", rvalid_l_o, 0);
    drv_l(1'b0, 1'b1, 12'd10, '0);
    tick(); tick();
    chk("R6 same-port read after write", {rvalid_l_o, rdata_l_o}, {1'b1, 9'h111});
    drv_l(1'b1, 1'b1, '0, '0); tick();
  endtask

  task automatic t_cross();
    wr_l(12'd20, 9'h011);
    // k=0
    drv_l(1'b0, 1'b0, 12'd20, 9'h0EE); drv_r(1'b0, 1'b1, 12'd20, '0);
    tick(); drv_l(1'b1, 1'b1, '0, '0); tick();
    chk("R7 k0 old data", rdata_r_o, 9'h011);
    drv_r(1'b1, 1'b1, '0, '0); tick(); tick();
    // k=1
    drv_l(1'b0, 1'b0, 12'd20, 9'h033);
    tick(); drv_l(1'b1, 1'b1, '0, '0); drv_r(1'b0, 1'b1, 12'd20, '0);
    tick(); tick();
    chk("R7 k1 old data", rdata_r_o, 9'h0EE);
    drv_r(1'b1, 1'b1, '0, '0); tick(); tick();
    // k=2
    drv_l(1'b0, 1'b0, 12'd20, 9'h044);
    tick(); drv_l(1'b1, 1'b1, '0, '0);
    tick(); drv_r(1'b0, 1'b1, 12'd20, '0);
    tick(); tick();
    chk("R7 k2 new data", rdata_r_o, 9'h044);
    drv_r(1'b1, 1'b1, '0, '0); tick(); tick();
    // right writes, left reads at k=1 then k=2
    drv_r(1'b0, 1'b0, 12'd20, 9'h155);
    tick(); drv_r(1'b1, 1'b1, '0, '0); drv_l(1'b0, 1'b1, 12'd20, '0);
    tick(); tick();
    chk("R7 reverse k1 old data", rdata_l_o, 9'h044);
    tick();
    chk("R7 reverse k2 new data", rdata_l_o, 9'h155);
    drv_l(1'b1, 1'b1, '0, '0); tick();
  endtask

  task automatic t_collide();
    drv_l(1'b0, 1'b0, 12'd30, 9'h0AA); drv_r(1'b0, 1'b0, 12'd30, 9'h055);
    tick(); drv_l(1'b1, 1'b1, '0, '0); drv_r(1'b1, 1'b1, '0, '0); tick();
    rd_r(12'd30, 9'h0AA, "R8 left wins via right");
    rd_l(12'd30, 9'h0AA, "R8 left wins via left");
    drv_l(1'b0, 1'b0, 12'd31, 9'h101); drv_r(1'b0, 1'b0, 12'd32, 9'h102);
    tick(); drv_l(1'b1, 1'b1, '0, '0); drv_r(1'b1, 1'b1, '0, '0); tick();
    rd_l(12'd32, 9'h102, "R8 distinct right");
    rd_r(12'd31, 9'h101, "R8 distinct left");
    wr_r(12'd30, 9'h077);
    rd_l(12'd30, 9'h077, "R8 later right write");
    drv_l(1'b1, 1'b1, '0, '0); drv_r(1'b1, 1'b1, '0, '0); tick();
  endtask

  task automatic t_hold();
    rd_l(12'd0, 9'h1FF, "R3 setup");
    drv_l(1'b0, 1'b1, 12'd4095, '0); cke_l_ni = 1'b1;
    tick(); tick(); tick();
    chk("R3 output frozen", {rvalid_l_o, rdata_l_o}, {1'b1, 9'h1FF});
    drv_l(1'b0, 1'b0, 12'd7, 9'h1EE); cke_l_ni = 1'b1;
    tick(); tick();
    drv_l(1'b1, 1'b1, '0, '0); tick();
    rd_l(12'd7, 9'h003, "R3 held write not stored");
  endtask

  task automatic t_desel();
    rd_l(12'd4095, 9'h0A5, "R4 setup");
    drv_l(1'b1, 1'b1, 12'd4095, '0);
    tick();
    chk("R4 deselect drops valid", rvalid_l_o, 0);
    drv_l(1'b1, 1'b0, 12'd4095, 9'h000);
    tick(); tick();
    chk("R4 deselected write valid", rvalid_l_o, 0);
    drv_l(1'b1, 1'b1, '0, '0); tick();
    rd_l(12'd4095, 9'h0A5, "R4 deselected write not stored");
  endtask

  task automatic t_oe();
    rd_r(12'd123, 9'h15A, "R5 setup");
    #3 oe_r_ni = 1'b1;
    #1 chk("R5 oe high drops valid", rvalid_r_o, 0);
    oe_r_ni = 1'b0;
    #1 chk("R5 oe low restores valid", {rvalid_r_o, rdata_r_o}, {1'b1, 9'h15A});
    tick();
  endtask

  initial begin
    drv_l(1'b1, 1'b1, '0, '0); drv_r(1'b1, 1'b1, '0, '0);
    oe_l_ni = 1'b0; oe_r_ni = 1'b0;
    #2 rst_ni = 1'b0;
    repeat (3) tick();
    t_reset();
    t_basic();
    t_latency();
    t_same_port();
    t_cross();
    t_collide();
    t_hold();
    t_desel();
    t_oe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule